// File: doc/BRIEF.md
# Flash Command Sequencer with Status Register

This block sits between a host write/read strobe interface and a NOR-style flash array model. It turns single-cycle and two-cycle command writes into word-program and sector-erase operations. The length of each operation is modelled by a cycle counter that can be loaded, frozen and restarted. A running program or erase can be suspended and later resumed from the cycle where it stopped. While an erase is suspended, a single word may be programmed.

An 8-bit status register reports the sequencer's progress. It combines flags that the sequencer raises and drops itself with error flags that stay set until software writes a clear command. A read-mode selector chooses what a read strobe captures into the read holding register: array data, status, identifier data or query-table data. Two inputs gate every program and erase when it is confirmed: a sector-lock flag for the addressed sector and a programming-voltage-good flag. When an operation starts, the block issues a one-cycle request strobe to the array, carrying the latched address and data.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `read_mode` is 0 (array), `rd_q` is 0, no request strobe is high, and the status value is 80h. The `read_mode` encoding is 0 array, 1 status, 2 identifier, 3 query.
- R2: When no operation is active, command bytes on `wr_data[7:0]` select the read mode as follows: FFh array, 70h status, 90h identifier, 98h query. A status read captures `{8'h00, status}`, and status bit 0 always reads 0.
- R3: When no operation is active, 40h (or 10h) followed by a data write starts a word program. The cycle after the data write, `prog_req` is high for one cycle with that address and data on `op_addr`/`op_data`. Status bit 7 (ready) then reads 0 for PROG_CYC cycles and returns to 1. The read mode becomes status.
- R4: 20h followed by D0h starts a sector erase. `erase_req` pulses for one cycle, and bit 7 reads 0 for ERASE_CYC cycles.
- R5: 20h followed by any byte other than D0h starts nothing. It sets status bits 5 and 4 together.
- R6: If `vpp_ok` is low when a program or erase is confirmed, the operation is aborted with no request strobe, and status bit 3 is set. This check takes precedence over the lock check, so bit 1 is then left unchanged.
- R7: If `sector_locked` is high (and `vpp_ok` high) when a program or erase is confirmed, the operation is aborted with no request strobe, and status bit 1 is set.
- R8: Bits 5, 4, 3 and 1 are sticky. Only the clear command 50h, written with no operation active, or reset clears them. Bits 7, 6 and 2 follow the sequencer state.
- R9: While a program or erase runs, only 70h (select status) and B0h (suspend) take effect. Every other byte, including D0h, is ignored.
- R10: After B0h, the operation counter freezes. After SUSP_LAT cycles, bit 7 and the matching suspend bit are set: bit 6 for an erase, bit 2 for a program. D0h clears both and runs the remaining cycles of the operation.
- R11: While an erase is suspended, FFh, 70h, 90h, 98h, program (40h/10h) and D0h resume are accepted. 20h and 50h are ignored. A program started here reads bit 7 = 0 with bit 6 = 1, and on completion returns to the erase-suspended state (C0h).
- R12: While a program is suspended, only FFh, 70h, 90h, 98h and D0h are accepted. A new program command is ignored.
- R13: `rd_q` changes only on a cycle with `rd_en` high, so a captured status value stays put while the sequencer moves on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command/data write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data; command byte in bits 7:0 |
| rd_en | input | 1 | Read strobe; captures the selected source into `rd_q` |
| arr_q | input | DW | Array read data |
| id_q | input | DW | Identifier read data |
| cfi_q | input | DW | Query-table read data |
| sector_locked | input | 1 | Addressed sector is write-protected |
| vpp_ok | input | 1 | Programming voltage is present |
| rd_q | output | DW | Read holding register |
| read_mode | output | 2 | Current read source |
| prog_req | output | 1 | One-cycle word-program request |
| erase_req | output | 1 | One-cycle sector-erase request |
| op_addr | output | AW | Address of the requested operation |
| op_data | output | DW | Data of the requested program |

## Verification
The bench tries the decoder with directed sequences in each sequencer state. An accepted byte is told apart from an ignored one by the read source it selects and by the request strobes it does or does not cause. A constrained-random series mixes programs, erases, malformed erase pairs, clears and ignored codes under random voltage and lock inputs. It compares the sticky bits with a bench model that shows whether errors accumulate and whether only the clear command removes them. Suspend/resume runs compare ready and suspend flags at recorded clock edges with the edge arithmetic of the counters. These runs separate a counter that freezes from one that restarts or keeps running.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

   localparam logic [7:0] C_READ     = 8'hFF;
   localparam logic [7:0] C_ERASE    = 8'h20;
   localparam logic [7:0] C_GO       = 8'hD0;
   localparam logic [7:0] C_PROG     = 8'h40;
   localparam logic [7:0] C_PROG_ALT = 8'h10;
   localparam logic [7:0] C_SUSP     = 8'hB0;
   localparam logic [7:0] C_STAT     = 8'h70;
   localparam logic [7:0] C_CLR      = 8'h50;
   localparam logic [7:0] C_ID       = 8'h90;
   localparam logic [7:0] C_CFI      = 8'h98;

   typedef enum logic [3:0] {
      K_NONE, K_READ, K_STAT, K_CLR, K_ID, K_CFI,
      K_ERASE, K_PROG, K_SUSP, K_GO
   } cmd_kind_t;

   typedef enum logic [3:0] {
      ST_IDLE, ST_ERS_SETUP, ST_PRG_SETUP, ST_PRG_RUN, ST_ERS_RUN,
      ST_PRG_SPEND, ST_ERS_SPEND, ST_PRG_SUSP, ST_ERS_SUSP,
      ST_NPRG_SETUP, ST_NPRG_RUN
   } seq_state_t;

   typedef enum logic [1:0] {
      MD_ARRAY  = 2'd0,
      MD_STATUS = 2'd1,
      MD_ID     = 2'd2,
      MD_CFI    = 2'd3
   } rd_mode_t;

endpackage

// File: rtl/fcs_decode.sv
module fcs_decode
   import fcs_pkg::*;
#(
   parameter bit ALT_PROG = 1'b1
) (
   input  logic [7:0] code,
   output cmd_kind_t  kind
);

   logic alt_hit;

   generate
      if (ALT_PROG) begin : g_alt
         assign alt_hit = (code == C_PROG_ALT);
      end else begin : g_no_alt
         assign alt_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      case (code)
         C_READ:  kind = K_READ;
         C_STAT:  kind = K_STAT;
         C_CLR:   kind = K_CLR;
         C_ID:    kind = K_ID;
         C_CFI:   kind = K_CFI;
         C_ERASE: kind = K_ERASE;
         C_PROG:  kind = K_PROG;
         C_SUSP:  kind = K_SUSP;
         C_GO:    kind = K_GO;
         default: kind = alt_hit ? K_PROG : K_NONE;
      endcase
   end

endmodule

// File: rtl/fcs_op_timer.sv
module fcs_op_timer #(
   parameter int CYC = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic done
);

   localparam int W = $clog2(CYC + 1);

   generate
      if (CYC < 1) begin : g_bad_cyc
         $error("fcs_op_timer: CYC must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= W'(CYC);
      else if (run && cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign done = run && (cnt == W'(1));

   AST_TIMER_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !run) |=> $stable(cnt)) else $error("timer moved while frozen"); // R10

endmodule

// File: rtl/fcs_status.sv
module fcs_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_lock,
   input  logic       set_vpp,
   input  logic       set_seq,
   input  logic       clr,
   input  logic       ready,
   input  logic       esusp,
   input  logic       psusp,
   output logic [7:0] status
);

   logic ee, pe, vl, lk;
   logic [3:0] sticky;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         ee <= 1'b0;
         pe <= 1'b0;
         vl <= 1'b0;
         lk <= 1'b0;
      end else begin
         if (set_lock) lk <= 1'b1;
         if (set_vpp)  vl <= 1'b1;
         if (set_seq) begin
            ee <= 1'b1;
            pe <= 1'b1;
         end
      end
   end

   assign sticky = {ee, pe, vl, lk};
   assign status = {ready, esusp, ee, pe, vl, psusp, lk, 1'b0};

   AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((sticky & $past(sticky)) == $past(sticky))) else $error("sticky bit dropped"); // R8

   AST_SEQ_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (set_seq && !clr) |=> (ee && pe)) else $error("sequence error not paired"); // R5

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import fcs_pkg::*;
#(
   parameter int AW        = 21,
   parameter int DW        = 16,
   parameter int PROG_CYC  = 12,
   parameter int ERASE_CYC = 40,
   parameter int SUSP_LAT  = 3,
   parameter bit ALT_PROG  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   input  logic [DW-1:0] arr_q,
   input  logic [DW-1:0] id_q,
   input  logic [DW-1:0] cfi_q,
   input  logic          sector_locked,
   input  logic          vpp_ok,
   output logic [DW-1:0] rd_q,
   output logic [1:0]    read_mode,
   output logic          prog_req,
   output logic          erase_req,
   output logic [AW-1:0] op_addr,
   output logic [DW-1:0] op_data
);

   localparam int SLW = $clog2(SUSP_LAT + 1);
   localparam int PAD = DW - 8;

   generate
      if (DW < 16) begin : g_bad_dw
         $error("flash_cmd_seq: DW must be at least 16");
      end
      if (SUSP_LAT < 1) begin : g_bad_lat
         $error("flash_cmd_seq: SUSP_LAT must be at least 1");
      end
      if (AW < 1) begin : g_bad_aw
         $error("flash_cmd_seq: AW must be at least 1");
      end
   endgenerate

   cmd_kind_t  kind;
   seq_state_t state, state_n;
   rd_mode_t   mode, mode_n;
   logic       prg_load, ers_load, prg_run, ers_run, prg_done, ers_done;
   logic       sl_load, sl_hit;
   logic [SLW-1:0] sl_cnt;
   logic       set_lock, set_vpp, set_seq, clr;
   logic       req_p, req_e;
   logic       ready, esusp, psusp;
   logic [7:0] status;

   fcs_decode #(.ALT_PROG(ALT_PROG)) u_dec (
      .code (wr_data[7:0]),
      .kind (kind)
   );

   fcs_op_timer #(.CYC(PROG_CYC)) u_prg_tmr (
      .clk (clk), .rst_n (rst_n), .load (prg_load), .run (prg_run), .done (prg_done)
   );

   fcs_op_timer #(.CYC(ERASE_CYC)) u_ers_tmr (
      .clk (clk), .rst_n (rst_n), .load (ers_load), .run (ers_run), .done (ers_done)
   );

   assign prg_run = (state == ST_PRG_RUN) || (state == ST_NPRG_RUN);
   assign ers_run = (state == ST_ERS_RUN);

   assign ready = state inside {ST_IDLE, ST_ERS_SETUP, ST_PRG_SETUP, ST_PRG_SUSP,
                                ST_ERS_SUSP, ST_NPRG_SETUP};
   assign esusp = state inside {ST_ERS_SUSP, ST_NPRG_SETUP, ST_NPRG_RUN};
   assign psusp = (state == ST_PRG_SUSP);

   fcs_status u_stat (
      .clk (clk), .rst_n (rst_n),
      .set_lock (set_lock), .set_vpp (set_vpp), .set_seq (set_seq), .clr (clr),
      .ready (ready), .esusp (esusp), .psusp (psusp),
      .status (status)
   );

   // suspend latency counter
   always_ff @(posedge clk) begin
      if (!rst_n)
         sl_cnt <= '0;
      else if (sl_load)
         sl_cnt <= SLW'(SUSP_LAT);
      else if ((state == ST_PRG_SPEND || state == ST_ERS_SPEND) && sl_cnt != '0)
         sl_cnt <= sl_cnt - 1'b1;
   end
   assign sl_hit = (sl_cnt == SLW'(1));

   always_comb begin
      state_n  = state;
      mode_n   = mode;
      prg_load = 1'b0;
      ers_load = 1'b0;
      sl_load  = 1'b0;
      set_lock = 1'b0;
      set_vpp  = 1'b0;
      set_seq  = 1'b0;
      clr      = 1'b0;
      req_p    = 1'b0;
      req_e    = 1'b0;
      case (state)
         ST_IDLE: if (wr_en) begin
            case (kind)
               K_READ:  mode_n  = MD_ARRAY;
               K_STAT:  mode_n  = MD_STATUS;
               K_ID:    mode_n  = MD_ID;
               K_CFI:   mode_n  = MD_CFI;
               K_CLR:   clr     = 1'b1;
               K_ERASE: state_n = ST_ERS_SETUP;
               K_PROG:  state_n = ST_PRG_SETUP;
               default: ;
            endcase
         end
         ST_PRG_SETUP, ST_NPRG_SETUP: if (wr_en) begin
            mode_n  = MD_STATUS;
            state_n = (state == ST_PRG_SETUP) ? ST_IDLE : ST_ERS_SUSP;
            if (!vpp_ok)
               set_vpp = 1'b1;
            else if (sector_locked)
               set_lock = 1'b1;
            else begin
               prg_load = 1'b1;
               req_p    = 1'b1;
               state_n  = (state == ST_PRG_SETUP) ? ST_PRG_RUN : ST_NPRG_RUN;
            end
         end
         ST_ERS_SETUP: if (wr_en) begin
            mode_n  = MD_STATUS;
            state_n = ST_IDLE;
            if (kind != K_GO)
               set_seq = 1'b1;
            else if (!vpp_ok)
               set_vpp = 1'b1;
            else if (sector_locked)
               set_lock = 1'b1;
            else begin
               ers_load = 1'b1;
               req_e    = 1'b1;
               state_n  = ST_ERS_RUN;
            end
         end
         ST_PRG_RUN, ST_ERS_RUN: begin
            if (wr_en && kind == K_STAT) mode_n = MD_STATUS;
            if (prg_done || ers_done)
               state_n = ST_IDLE;
            else if (wr_en && kind == K_SUSP) begin
               sl_load = 1'b1;
               state_n = (state == ST_PRG_RUN) ? ST_PRG_SPEND : ST_ERS_SPEND;
            end
         end
         ST_PRG_SPEND, ST_ERS_SPEND: begin
            if (wr_en && kind == K_STAT) mode_n = MD_STATUS;
            if (sl_hit)
               state_n = (state == ST_PRG_SPEND) ? ST_PRG_SUSP : ST_ERS_SUSP;
         end
         ST_PRG_SUSP, ST_ERS_SUSP: if (wr_en) begin
            case (kind)
               K_READ:  mode_n = MD_ARRAY;
               K_STAT:  mode_n = MD_STATUS;
               K_ID:    mode_n = MD_ID;
               K_CFI:   mode_n = MD_CFI;
               K_GO:    state_n = (state == ST_PRG_SUSP) ? ST_PRG_RUN : ST_ERS_RUN;
               K_PROG:  if (state == ST_ERS_SUSP) state_n = ST_NPRG_SETUP;
               default: ;
            endcase
         end
         ST_NPRG_RUN: begin
            if (wr_en && kind == K_STAT) mode_n = MD_STATUS;
            if (prg_done) state_n = ST_ERS_SUSP;
         end
         default: state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         mode      <= MD_ARRAY;
         prog_req  <= 1'b0;
         erase_req <= 1'b0;
         op_addr   <= '0;
         op_data   <= '0;
      end else begin
         state     <= state_n;
         mode      <= mode_n;
         prog_req  <= req_p;
         erase_req <= req_e;
         if (req_p || req_e) begin
            op_addr <= wr_addr;
            op_data <= wr_data;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rd_q <= '0;
      else if (rd_en) begin
         case (mode)
            MD_ARRAY:  rd_q <= arr_q;
            MD_STATUS: rd_q <= {{PAD{1'b0}}, status};
            MD_ID:     rd_q <= id_q;
            default:   rd_q <= cfi_q;
         endcase
      end
   end

   assign read_mode = mode;

   AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog_req, erase_req})) else $error("two requests at once"); // R3

   AST_PROG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> !status[7]) else $error("ready during program start"); // R3

   AST_ERASE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> !status[7]) else $error("ready during erase start"); // R4

   AST_SUSP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(status[6] && status[2])) else $error("both suspend flags set"); // R10

   AST_NO_ERASE_IN_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ERS_SUSP) |=> !erase_req) else $error("erase from suspend"); // R11

   AST_RDQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_q)) else $error("read register moved"); // R13

endmodule

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;

   localparam int AW = 21;
   localparam int DW = 16;
   localparam int PC = 12;
   localparam int EC = 40;
   localparam int SL = 3;
   localparam logic [15:0] ARR = 16'hA5A5;
   localparam logic [15:0] IDV = 16'h1111;
   localparam logic [15:0] CFV = 16'h2222;

   logic          clk = 1'b0;
   logic          rst_n, wr_en, rd_en, sector_locked, vpp_ok;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic [DW-1:0] rd_q, op_data;
   logic [AW-1:0] op_addr;
   logic [1:0]    read_mode;
   logic          prog_req, erase_req;

   int tests = 0, fails = 0, cyc = 0, nprog = 0, nerase = 0, last_wr = 0, last_rd = 0;
   bit finished = 1'b0;
   logic [15:0] rv;

   always #4 clk = ~clk;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (prog_req)  nprog  <= nprog + 1;
      if (erase_req) nerase <= nerase + 1;
   end

   flash_cmd_seq #(.AW(AW), .DW(DW), .PROG_CYC(PC), .ERASE_CYC(EC), .SUSP_LAT(SL)) uut (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
      .rd_en (rd_en), .arr_q (ARR), .id_q (IDV), .cfi_q (CFV),
      .sector_locked (sector_locked), .vpp_ok (vpp_ok),
      .rd_q (rd_q), .read_mode (read_mode), .prog_req (prog_req), .erase_req (erase_req),
      .op_addr (op_addr), .op_data (op_data)
   );

   function automatic logic [15:0] sv(bit r, bit es, bit ee, bit pe, bit vl, bit ps, bit lk);
      return {8'h00, r, es, ee, pe, vl, ps, lk, 1'b0};
   endfunction

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   // caller is at a negedge; returns at the next negedge
   task automatic wr(logic [15:0] d, logic [AW-1:0] a = '0);
      wr_en = 1'b1; wr_data = d; wr_addr = a;
      @(negedge clk);
      wr_en = 1'b0;
      last_wr = cyc;
   endtask

   task automatic rd();
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      last_rd = cyc;
      rv = rd_q;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int p0, ps, pz, rem, np0, ne0;
      bit s_ee, s_pe, s_vl, s_lk;
      int np_exp, ne_exp;
      logic [31:0] seed;
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0; wr_addr = '0;
      sector_locked = 1'b0; vpp_ok = 1'b1;
      seed = $urandom(32'd20240611);
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 mode", 32'(read_mode), 32'd0);
      chk("R1 rd_q", 32'(rd_q), 32'h0);
      chk("R1 req", 32'({prog_req, erase_req}), 32'h0);
      wr(16'h0070); rd();
      chk("R1 status", 32'(rv), 32'(sv(1,0,0,0,0,0,0)));

      // R2 mode selection
      wr(16'h00FF); rd(); chk("R2 array", 32'(rv), 32'(ARR));
      wr(16'h0090); rd(); chk("R2 id", 32'(rv), 32'(IDV));
      chk("R2 mode id", 32'(read_mode), 32'd2);
      wr(16'h0098); rd(); chk("R2 cfi", 32'(rv), 32'(CFV));
      wr(16'h0070); rd(); chk("R2 status upper zero", 32'(rv), 32'h0080);

      // R3 word program, R9 ignored commands while running
      np0 = nprog;
      wr(16'h0040);
      wr(16'h5A3C, 21'h012345);
      p0 = last_wr;
      chk("R3 prog_req", 32'(prog_req), 32'd1);
      chk("R3 op_addr", 32'(op_addr), 32'h012345);
      chk("R3 op_data", 32'(op_data), 32'h5A3C);
      chk("R3 mode status", 32'(read_mode), 32'd1);
      wr(16'h0090); rd();
      chk("R9 id ignored", 32'(rv), 32'(sv(last_rd > p0 + PC, 0,0,0,0,0,0)));
      wr(16'h00FF); wr(16'h0040); wr(16'h00D0); rd();
      chk("R9 read ignored", 32'(rv), 32'(sv(last_rd > p0 + PC, 0,0,0,0,0,0)));
      idle(PC);
      rd();
      chk("R3 ready after PROG_CYC", 32'(rv), 32'h0080);
      chk("R9 single prog", 32'(nprog - np0), 32'd1);

      // R3 alternate opcode 10h and exact end edge
      wr(16'h0010); wr(16'h0001, 21'h000002); p0 = last_wr;
      idle(PC - 2); rd();
      chk("R3 busy edge", 32'(rv), 32'(sv(last_rd > p0 + PC, 0,0,0,0,0,0)));
      rd();
      chk("R3 done edge", 32'(rv), 32'(sv(last_rd > p0 + PC, 0,0,0,0,0,0)));

      // R4 erase, R13 hold
      ne0 = nerase;
      wr(16'h0020); wr(16'h00D0, 21'h010000); p0 = last_wr;
      chk("R4 erase_req", 32'(erase_req), 32'd1);
      rd();
      chk("R4 busy", 32'(rv), 32'h0000);
      idle(EC + 2);
      chk("R13 held", 32'(rd_q), 32'h0000);
      rd();
      chk("R4 done", 32'(rv), 32'h0080);
      chk("R4 count", 32'(nerase - ne0), 32'd1);

      // R5 bad confirm, R8 sticky
      ne0 = nerase;
      wr(16'h0020); wr(16'h0033); rd();
      chk("R5 seq error", 32'(rv), 32'(sv(1,0,1,1,0,0,0)));
      chk("R5 no erase", 32'(nerase - ne0), 32'd0);
      wr(16'h00FF); wr(16'h0070); rd();
      chk("R8 sticky kept", 32'(rv), 32'(sv(1,0,1,1,0,0,0)));
      wr(16'h0050); rd();
      chk("R8 cleared", 32'(rv), 32'h0080);

      // R6 vpp low with lock
      np0 = nprog;
      wr(16'h0040); vpp_ok = 1'b0; sector_locked = 1'b1;
      wr(16'h1234, 21'h000100);
      vpp_ok = 1'b1; sector_locked = 1'b0;
      rd();
      chk("R6 vpp abort", 32'(rv), 32'(sv(1,0,0,0,1,0,0)));
      chk("R6 no prog", 32'(nprog - np0), 32'd0);
      wr(16'h0050);

      // R7 locked erase
      ne0 = nerase;
      wr(16'h0020); sector_locked = 1'b1;
      wr(16'h00D0, 21'h020000);
      sector_locked = 1'b0;
      rd();
      chk("R7 lock abort", 32'(rv), 32'(sv(1,0,0,0,0,0,1)));
      chk("R7 no erase", 32'(nerase - ne0), 32'd0);
      wr(16'h0050);

      // R10/R12 program suspend and resume
      wr(16'h0040); wr(16'hBEEF, 21'h000200); p0 = last_wr;
      idle(2);
      wr(16'h00B0); ps = last_wr; rem = PC - (ps - p0);
      rd();
      chk("R10 pending", 32'(rv), 32'(sv(last_rd - 1 >= ps + SL, 0,0,0,0, last_rd - 1 >= ps + SL, 0)));
      idle(SL);
      rd();
      chk("R10 prog suspended", 32'(rv), 32'(sv(1,0,0,0,0,1,0)));
      np0 = nprog;
      wr(16'h0040); wr(16'h0090); rd();
      chk("R12 id accepted", 32'(rv), 32'(IDV));
      chk("R12 program ignored", 32'(nprog - np0), 32'd0);
      wr(16'h0070); wr(16'h00D0); pz = last_wr;
      rd();
      chk("R10 resumed busy", 32'(rv), 32'h0000);
      idle(rem - 3); rd();
      chk("R10 remaining busy", 32'(rv), 32'(sv(last_rd - 1 >= pz + rem, 0,0,0,0,0,0)));
      idle(2); rd();
      chk("R10 remaining done", 32'(rv), 32'(sv(last_rd - 1 >= pz + rem, 0,0,0,0,0,0)));

      // R11 erase suspend with nested program
      wr(16'h0020); wr(16'h00D0, 21'h030000); p0 = last_wr;
      idle(5);
      wr(16'h00B0); ps = last_wr; rem = EC - (ps - p0);
      idle(SL + 1); rd();
      chk("R11 erase suspended", 32'(rv), 32'h00C0);
      ne0 = nerase; np0 = nprog;
      wr(16'h0020); wr(16'h0050); rd();
      chk("R11 erase/clear ignored", 32'(rv), 32'h00C0);
      wr(16'h0040); wr(16'h0F0F, 21'h040000);
      rd();
      chk("R11 nested busy", 32'(rv), 32'h0040);
      idle(PC + 1); rd();
      chk("R11 back to suspend", 32'(rv), 32'h00C0);
      chk("R11 counts", 32'({16'(nerase - ne0), 16'(nprog - np0)}), 32'h0000_0001);
      wr(16'h00FF); rd();
      chk("R11 array read", 32'(rv), 32'(ARR));
      wr(16'h0070); wr(16'h00D0); pz = last_wr;
      rd();
      chk("R11 resumed", 32'(rv), 32'h0000);
      idle(rem); rd();
      chk("R10 erase remaining", 32'(rv), 32'(sv(last_rd - 1 >= pz + rem, 0,0,0,0,0,0)));

      // R8 random mix with sticky model
      s_ee = 0; s_pe = 0; s_vl = 0; s_lk = 0;
      wr(16'h0050);
      np_exp = nprog; ne_exp = nerase;
      for (int it = 0; it < 40; it++) begin
         int k;
         bit v, l;
         k = int'($urandom % 5);
         v = ($urandom % 4) != 0;
         l = ($urandom % 3) == 0;
         case (k)
            0: begin
               wr(16'h0040); vpp_ok = v; sector_locked = l;
               wr(16'($urandom), AW'($urandom));
               if (!v) s_vl = 1; else if (l) s_lk = 1; else np_exp++;
            end
            1: begin
               wr(16'h0020); vpp_ok = v; sector_locked = l;
               wr(16'h00D0, AW'($urandom));
               if (!v) s_vl = 1; else if (l) s_lk = 1; else ne_exp++;
            end
            2: begin
               wr(16'h0020); wr(16'h0033);
               s_ee = 1; s_pe = 1;
            end
            3: begin
               wr(16'h0050);
               s_ee = 0; s_pe = 0; s_vl = 0; s_lk = 0;
            end
            default: wr(16'h00B0);
         endcase
         vpp_ok = 1'b1; sector_locked = 1'b0;
         idle(EC + 2);
         wr(16'h0070); rd();
         chk("R8 random status", 32'(rv), 32'(sv(1,0,s_ee,s_pe,s_vl,0,s_lk)));
      end
      chk("R3 random prog count", 32'(nprog), 32'(np_exp));
      chk("R4 random erase count", 32'(nerase), 32'(ne_exp));

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule